// File: doc/BRIEF.md
# DRAM Address Mapper With Ordering

This block splits a linear byte address into the chip-select, row, bank and column fields that a DRAM command path needs. The column, bank and row field widths and the chip-select count (one or two) come from configuration inputs. An interface-width code sets how many low byte-offset bits are dropped before the column field. Error-correction lanes are not counted toward the addressable width.

Two layouts are supported, listed from the most to the least significant field. Order 0 is chip, row, bank, column. Order 2 is row, chip, bank, column. With the default `FORCE_ORDER=1` the order follows the chip-select count: one chip select selects order 0 and two select order 2. With `FORCE_ORDER=0` the requested order code is used, and any code other than 0 or 2 falls back to order 0.

The block also reports the total addressable size as a base-2 logarithm and flags addresses that fall outside it. Each request costs one register stage.

Top module: `dram_addr_map`

## Requirements
- R1: `out_valid` rises exactly one clock after an accepted `in_valid` and is low otherwise. Reset clears it.
- R2: The chip-select count is `cfg_cs_bit`+1. When `cfg_cs_bit` is 0, `out_cs` is always 0 and the chip field takes no address bits.
- R3: With `FORCE_ORDER=1`, `out_order` is 0 for one chip select and 2 for two, whatever the value of `cfg_order`.
- R4: In order 0, after the byte offset is removed, the shifted address holds, from bit 0 upward: the column, then the bank, then the row, then the chip bit.
- R5: In order 2, after the byte offset is removed, the shifted address holds, from bit 0 upward: the column, then the bank, then the chip bit, then the row.
- R6: `cfg_width` selects how many byte-offset bits are discarded below the column: code 1 (16-bit) drops 1 bit and code 2 (32-bit) drops 2 bits. Code 0 and codes 5 to 7 count as 8-bit and drop none.
- R7: `out_size_log2` equals row + bank + column + `cfg_cs_bit` + offset bits, so the byte size is 2^(row+bank+col) × chip selects × bytes per beat.
- R8: Code 3 (16-bit with ECC) counts as 16-bit and code 4 (32-bit with ECC) counts as 32-bit, for both the offset and the size.
- R9: A `cfg_row_bits` value of 0 or above `ROW_MAX` (31) is replaced by the parameter `ROW_DEFAULT` (14) in the field split and in the size.
- R10: `out_of_range` is 1 exactly when the address is at or above 2^`out_size_log2`. While it is 1, the field values are not defined.
- R11: With `FORCE_ORDER=0`, a `cfg_order` of 2 gives order 2 and every other code gives order 0. `out_order` is never 1 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_col_bits | input | 4 | Column field width |
| cfg_bank_bits | input | 2 | Bank field width |
| cfg_row_bits | input | 6 | Stored row field width (0 or above 31 is invalid) |
| cfg_cs_bit | input | 1 | Chip selects minus one |
| cfg_order | input | 2 | Requested order code |
| cfg_width | input | 3 | Interface width code |
| in_valid | input | 1 | Address request strobe |
| in_addr | input | 32 | Linear byte address |
| out_valid | output | 1 | Mapped result valid |
| out_cs | output | 1 | Chip-select index |
| out_row | output | 31 | Row field |
| out_bank | output | 3 | Bank field |
| out_col | output | 12 | Column field |
| out_of_range | output | 1 | Address beyond addressable size |
| out_size_log2 | output | 6 | log2 of addressable bytes |
| out_order | output | 2 | Effective order code |

## Verification
The assertions assume that the configuration inputs stay constant from the cycle a request is accepted until its result appears. They also assume that the column width never exceeds `COL_MAX` and the bank width never exceeds `BANK_MAX`. The stimulus respects both: it changes configuration only on cycles with `in_valid` low and leaves one idle cycle before the next request. Every configuration it applies keeps column and bank widths within range. Row widths are deliberately driven outside the valid range, because the fallback accepts any row value.

// File: rtl/dam_pkg.sv
package dam_pkg;
   // interface width codes
   localparam logic [2:0] WCODE_X16     = 3'd1;
   localparam logic [2:0] WCODE_X32     = 3'd2;
   localparam logic [2:0] WCODE_X16_ECC = 3'd3;
   localparam logic [2:0] WCODE_X32_ECC = 3'd4;

   localparam logic [1:0] ORD_CHIP_TOP = 2'd0;
   localparam logic [1:0] ORD_CHIP_MID = 2'd2;

   // number of byte-offset bits under the column field
   function automatic logic [1:0] offset_bits(input logic [2:0] wcode);
      case (wcode)
         WCODE_X16, WCODE_X16_ECC: offset_bits = 2'd1;
         WCODE_X32, WCODE_X32_ECC: offset_bits = 2'd2;
         default:                  offset_bits = 2'd0;
      endcase
   endfunction

   function automatic logic [63:0] low_mask(input int unsigned n);
      low_mask = (64'd1 << n) - 64'd1;
   endfunction
endpackage

// File: rtl/dam_geometry.sv
module dam_geometry
   import dam_pkg::*;
#(
   parameter int COL_MAX     = 12,
   parameter int BANK_MAX    = 3,
   parameter int ROW_MAX     = 31,
   parameter int ROW_CFG_W   = 6,
   parameter int ROW_DEFAULT = 14,
   parameter bit FORCE_ORDER = 1'b1,
   localparam int COL_CW     = $clog2(COL_MAX + 1),
   localparam int BANK_CW    = $clog2(BANK_MAX + 1),
   localparam int SZ_W       = $clog2(ROW_MAX + COL_MAX + BANK_MAX + 4)
) (
   input  logic [COL_CW-1:0]    cfg_col_bits,
   input  logic [BANK_CW-1:0]   cfg_bank_bits,
   input  logic [ROW_CFG_W-1:0] cfg_row_bits,
   input  logic                 cfg_cs_bit,
   input  logic [1:0]           cfg_order,
   input  logic [2:0]           cfg_width,
   output logic [ROW_CFG_W-1:0] row_w,
   output logic [1:0]           off_w,
   output logic [1:0]           order,
   output logic [SZ_W-1:0]      size_log2
);
   logic row_bad;

   // R9 stored row width outside 1..ROW_MAX falls back to the default
   assign row_bad = (cfg_row_bits == '0) || (int'(cfg_row_bits) > ROW_MAX);
   assign row_w   = row_bad ? ROW_CFG_W'(ROW_DEFAULT) : cfg_row_bits;

   // R6 R8 ECC lanes add no address bits
   assign off_w = offset_bits(cfg_width);

   // R7
   assign size_log2 = SZ_W'(row_w) + SZ_W'(cfg_bank_bits) + SZ_W'(cfg_col_bits)
                    + SZ_W'(cfg_cs_bit) + SZ_W'(off_w);

   generate
      if (FORCE_ORDER) begin : g_forced
         logic unused_req_order;
         assign unused_req_order = ^cfg_order;
         // R3
         assign order = cfg_cs_bit ? ORD_CHIP_MID : ORD_CHIP_TOP;
      end else begin : g_free
         // R11
         assign order = (cfg_order == ORD_CHIP_MID) ? ORD_CHIP_MID : ORD_CHIP_TOP;
      end
   endgenerate
endmodule

// File: rtl/dam_field_split.sv
module dam_field_split
   import dam_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int COL_MAX   = 12,
   parameter int BANK_MAX  = 3,
   parameter int ROW_MAX   = 31,
   parameter int ROW_CFG_W = 6,
   localparam int COL_CW   = $clog2(COL_MAX + 1),
   localparam int BANK_CW  = $clog2(BANK_MAX + 1),
   localparam int SZ_W     = $clog2(ROW_MAX + COL_MAX + BANK_MAX + 4)
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [COL_CW-1:0]    col_w,
   input  logic [BANK_CW-1:0]   bank_w,
   input  logic [ROW_CFG_W-1:0] row_w,
   input  logic                 cs_w,
   input  logic [1:0]           off_w,
   input  logic [1:0]           order,
   input  logic [SZ_W-1:0]      size_log2,
   output logic                 chip,
   output logic [ROW_MAX-1:0]   row,
   output logic [BANK_MAX-1:0]  bank,
   output logic [COL_MAX-1:0]   col,
   output logic                 beyond
);
   logic [ADDR_W-1:0] beat, above_col, above_bank, row_src, chip_src;

   assign beat       = addr >> off_w;          // R6
   assign above_col  = beat >> col_w;
   assign above_bank = above_col >> bank_w;

   assign col  = COL_MAX'(beat & ADDR_W'(low_mask(int'(col_w))));
   assign bank = BANK_MAX'(above_col & ADDR_W'(low_mask(int'(bank_w))));

   always_comb begin
      if (order == ORD_CHIP_MID) begin         // R5
         chip_src = above_bank;
         row_src  = above_bank >> cs_w;
      end else begin                           // R4
         row_src  = above_bank;
         chip_src = above_bank >> row_w;
      end
   end

   assign row  = ROW_MAX'(row_src & ADDR_W'(low_mask(int'(row_w))));
   assign chip = chip_src[0] & cs_w;           // R2

   // R10
   assign beyond = |(addr >> size_log2);
endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
   import dam_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int COL_MAX     = 12,
   parameter int BANK_MAX    = 3,
   parameter int ROW_MAX     = 31,
   parameter int ROW_CFG_W   = 6,
   parameter int ROW_DEFAULT = 14,
   parameter bit FORCE_ORDER = 1'b1,
   localparam int COL_CW     = $clog2(COL_MAX + 1),
   localparam int BANK_CW    = $clog2(BANK_MAX + 1),
   localparam int SZ_W       = $clog2(ROW_MAX + COL_MAX + BANK_MAX + 4)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [COL_CW-1:0]    cfg_col_bits,
   input  logic [BANK_CW-1:0]   cfg_bank_bits,
   input  logic [ROW_CFG_W-1:0] cfg_row_bits,
   input  logic                 cfg_cs_bit,
   input  logic [1:0]           cfg_order,
   input  logic [2:0]           cfg_width,
   input  logic                 in_valid,
   input  logic [ADDR_W-1:0]    in_addr,
   output logic                 out_valid,
   output logic                 out_cs,
   output logic [ROW_MAX-1:0]   out_row,
   output logic [BANK_MAX-1:0]  out_bank,
   output logic [COL_MAX-1:0]   out_col,
   output logic                 out_of_range,
   output logic [SZ_W-1:0]      out_size_log2,
   output logic [1:0]           out_order
);
   generate
      if (ROW_DEFAULT < 1 || ROW_DEFAULT > ROW_MAX) begin : g_bad_default
         $error("ROW_DEFAULT must lie in 1..ROW_MAX");
      end
      if (ROW_MAX >= (1 << ROW_CFG_W) || ROW_MAX > ADDR_W) begin : g_bad_rowmax
         $error("ROW_MAX does not fit ROW_CFG_W or ADDR_W");
      end
   endgenerate

   logic [ROW_CFG_W-1:0] row_w;
   logic [1:0]           off_w, order;
   logic [SZ_W-1:0]      size_log2;
   logic                 chip, beyond;
   logic [ROW_MAX-1:0]   row;
   logic [BANK_MAX-1:0]  bank;
   logic [COL_MAX-1:0]   col;

   dam_geometry #(
      .COL_MAX(COL_MAX), .BANK_MAX(BANK_MAX), .ROW_MAX(ROW_MAX),
      .ROW_CFG_W(ROW_CFG_W), .ROW_DEFAULT(ROW_DEFAULT), .FORCE_ORDER(FORCE_ORDER)
   ) i_geometry (
      .cfg_col_bits(cfg_col_bits), .cfg_bank_bits(cfg_bank_bits),
      .cfg_row_bits(cfg_row_bits), .cfg_cs_bit(cfg_cs_bit),
      .cfg_order(cfg_order), .cfg_width(cfg_width),
      .row_w(row_w), .off_w(off_w), .order(order), .size_log2(size_log2)
   );

   dam_field_split #(
      .ADDR_W(ADDR_W), .COL_MAX(COL_MAX), .BANK_MAX(BANK_MAX),
      .ROW_MAX(ROW_MAX), .ROW_CFG_W(ROW_CFG_W)
   ) i_split (
      .addr(in_addr), .col_w(cfg_col_bits), .bank_w(cfg_bank_bits),
      .row_w(row_w), .cs_w(cfg_cs_bit), .off_w(off_w), .order(order),
      .size_log2(size_log2), .chip(chip), .row(row), .bank(bank),
      .col(col), .beyond(beyond)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_cs        <= 1'b0;
         out_row       <= '0;
         out_bank      <= '0;
         out_col       <= '0;
         out_of_range  <= 1'b0;
         out_size_log2 <= '0;
         out_order     <= ORD_CHIP_TOP;
      end else begin
         out_valid     <= in_valid;            // R1
         out_size_log2 <= size_log2;
         out_order     <= order;
         if (in_valid) begin
            out_cs       <= chip;
            out_row      <= row;
            out_bank     <= bank;
            out_col      <= col;
            out_of_range <= beyond;
         end
      end
   end

   // R1
   valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R2
   single_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_cs_bit) |=> !out_cs);
   // R4
   col_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_col >> $past(cfg_col_bits)) == '0));
   // R5
   bank_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_bank >> $past(cfg_bank_bits)) == '0));
   // R9
   row_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_row >> $past(row_w)) == '0));
   // R11
   order_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_order == ORD_CHIP_TOP) || (out_order == ORD_CHIP_MID));
endmodule

// File: tb/test_dram_addr_map.sv
module test_dram_addr_map;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_col_bits = 4'd10;
   logic [1:0]  cfg_bank_bits = 2'd3;
   logic [5:0]  cfg_row_bits = 6'd15;
   logic        cfg_cs_bit = 1'b0;
   logic [1:0]  cfg_order = 2'd0;
   logic [2:0]  cfg_width = 3'd2;
   logic        in_valid = 1'b0;
   logic [31:0] in_addr = '0;

   logic        out_valid, out_cs, out_of_range;
   logic [30:0] out_row;
   logic [2:0]  out_bank;
   logic [11:0] out_col;
   logic [5:0]  out_size_log2;
   logic [1:0]  out_order;

   logic        f_valid, f_cs, f_oor;
   logic [30:0] f_row;
   logic [2:0]  f_bank;
   logic [11:0] f_col;
   logic [5:0]  f_szl;
   logic [1:0]  f_order;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_addr_map i_dram_addr_map (
      .clk(clk), .rst_n(rst_n), .cfg_col_bits(cfg_col_bits),
      .cfg_bank_bits(cfg_bank_bits), .cfg_row_bits(cfg_row_bits),
      .cfg_cs_bit(cfg_cs_bit), .cfg_order(cfg_order), .cfg_width(cfg_width),
      .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
      .out_cs(out_cs), .out_row(out_row), .out_bank(out_bank),
      .out_col(out_col), .out_of_range(out_of_range),
      .out_size_log2(out_size_log2), .out_order(out_order)
   );

   dram_addr_map #(.FORCE_ORDER(1'b0)) i_dram_addr_map_free (
      .clk(clk), .rst_n(rst_n), .cfg_col_bits(cfg_col_bits),
      .cfg_bank_bits(cfg_bank_bits), .cfg_row_bits(cfg_row_bits),
      .cfg_cs_bit(cfg_cs_bit), .cfg_order(cfg_order), .cfg_width(cfg_width),
      .in_valid(in_valid), .in_addr(in_addr), .out_valid(f_valid),
      .out_cs(f_cs), .out_row(f_row), .out_bank(f_bank),
      .out_col(f_col), .out_of_range(f_oor),
      .out_size_log2(f_szl), .out_order(f_order)
   );

   typedef struct packed {
      logic        cs;
      logic [30:0] row;
      logic [2:0]  bank;
      logic [11:0] col;
   } fld_t;

   typedef struct {
      fld_t        fa;
      fld_t        fb;
      logic        oor;
      logic [5:0]  szl;
      logic [1:0]  ord_a;
      logic [1:0]  ord_b;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_total = 0;
   int   n_bad = 0;

   function automatic fld_t model(input logic [31:0] addr, input int c, input int b,
                                  input int r, input int s, input int off, input int ord);
      fld_t f;
      longint unsigned a;
      a = 64'(addr) >> off;
      f.col  = 12'(a & ((64'd1 << c) - 1));
      a = a >> c;
      f.bank = 3'(a & ((64'd1 << b) - 1));
      a = a >> b;
      if (ord == 2) begin
         f.cs  = (s != 0) ? a[0] : 1'b0;
         a = a >> s;
         f.row = 31'(a & ((64'd1 << r) - 1));
      end else begin
         f.row = 31'(a & ((64'd1 << r) - 1));
         a = a >> r;
         f.cs  = (s != 0) ? a[0] : 1'b0;
      end
      return f;
   endfunction

   task automatic set_cfg(input int c, input int b, input int r, input int s,
                          input int req, input int w);
      @(negedge clk);
      in_valid      = 1'b0;
      cfg_col_bits  = 4'(c);
      cfg_bank_bits = 2'(b);
      cfg_row_bits  = 6'(r);
      cfg_cs_bit    = 1'(s);
      cfg_order     = 2'(req);
      cfg_width     = 3'(w);
   endtask

   // driver: applies an address and queues the result the requirements predict
   task automatic send(input logic [31:0] addr, input string tag);
      exp_t e;
      int r, off, szl, oa, ob;
      r   = (cfg_row_bits == 0 || cfg_row_bits > 31) ? 14 : int'(cfg_row_bits);  // R9
      case (cfg_width)                                                          // R6 R8
         3'd1, 3'd3: off = 1;
         3'd2, 3'd4: off = 2;
         default:    off = 0;
      endcase
      szl = r + int'(cfg_bank_bits) + int'(cfg_col_bits) + int'(cfg_cs_bit) + off;  // R7
      oa  = cfg_cs_bit ? 2 : 0;               // R3
      ob  = (cfg_order == 2'd2) ? 2 : 0;      // R11
      e.fa    = model(addr, cfg_col_bits, cfg_bank_bits, r, cfg_cs_bit, off, oa);
      e.fb    = model(addr, cfg_col_bits, cfg_bank_bits, r, cfg_cs_bit, off, ob);
      e.oor   = (64'(addr) >= (64'd1 << szl));  // R10
      e.szl   = 6'(szl);
      e.ord_a = 2'(oa);
      e.ord_b = 2'(ob);
      e.tag   = tag;
      @(negedge clk);
      in_valid = 1'b1;
      in_addr  = addr;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: compares each result against the oldest queued prediction
   always @(negedge clk) begin
      if (rst_n && (out_valid || f_valid)) begin
         n_total++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R1 unexpected result valid=%0b/%0b expected none", out_valid, f_valid);
         end else begin
            exp_t e;
            fld_t ga, gb;
            logic ok;
            e  = exp_q.pop_front();
            ga = {out_cs, out_row, out_bank, out_col};
            gb = {f_cs, f_row, f_bank, f_col};
            ok = out_valid && f_valid && (out_of_range == e.oor) && (f_oor == e.oor)
                 && (out_size_log2 == e.szl) && (f_szl == e.szl)
                 && (out_order == e.ord_a) && (f_order == e.ord_b);
            if (!e.oor) ok = ok && (ga == e.fa) && (gb == e.fb);
            if (!ok) begin
               n_bad++;
               $display("FAIL %s actual fa=%h fb=%h oor=%0b/%0b szl=%0d/%0d ord=%0d/%0d expected fa=%h fb=%h oor=%0b szl=%0d ord=%0d/%0d",
                        e.tag, ga, gb, out_of_range, f_oor, out_size_log2, f_szl,
                        out_order, f_order, e.fa, e.fb, e.oor, e.szl, e.ord_a, e.ord_b);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1 reset state
      n_total++;
      if (out_valid !== 1'b0 || f_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset out_valid=%0b expected 0", out_valid);
      end
      rst_n = 1'b1;

      // one chip select, 32-bit, requested order 3 -> order 0 (R2 R4 R11)
      set_cfg(10, 3, 15, 0, 3, 2);
      send(32'h1234_5678, "R4");
      send(32'h3FFF_FFFC, "R10");   // last beat inside
      send(32'h4000_0000, "R10");   // first beat outside
      send(32'hFFFF_FFFF, "R10");
      for (int i = 1; i < 7; i++) send(32'(i * 32'h0913_5B7F) & 32'h3FFF_FFFF, "R2");
      idle(2);

      // two chip selects, 16-bit: forced order 2, requested 0 (R3 R5 R11)
      set_cfg(10, 3, 15, 1, 0, 1);
      for (int i = 1; i < 9; i++) send(32'(i * 32'h0527_3C41) & 32'h3FFF_FFFF, "R5");
      send(32'h2000_0000, "R5");    // chip bit alone set in order 0 vs 2
      send(32'h3FFF_FFFE, "R3");
      idle(2);

      // 32-bit with ECC counts as 32 (R8)
      set_cfg(10, 3, 15, 1, 2, 4);
      send(32'h7FFF_FFFC, "R8");
      send(32'h8000_0000, "R8");
      send(32'h5A5A_A5A4, "R8");
      idle(2);

      // 16-bit with ECC, stored row 0 -> default (R8 R9)
      set_cfg(10, 3, 0, 0, 1, 3);
      send(32'h0FFF_FFFE, "R9");
      send(32'h1000_0000, "R9");
      send(32'h0ABC_1234, "R8");
      idle(2);

      // stored row 40 -> default, code 6 counts as 8-bit (R6 R9)
      set_cfg(8, 2, 40, 1, 0, 6);
      send(32'h01FF_FFFF, "R6");
      send(32'h0200_0000, "R9");
      send(32'h0123_4567, "R6");
      idle(2);

      // widest geometry: size beyond address width, never out of range (R7)
      set_cfg(12, 3, 31, 1, 2, 2);
      send(32'hFFFF_FFFF, "R7");
      send(32'h8421_0842, "R7");
      idle(2);

      // 8-bit, one chip select, requested order 2 on the free instance (R6 R11)
      set_cfg(9, 2, 13, 0, 2, 0);
      send(32'h00FF_FFFF, "R6");
      send(32'h0100_0000, "R10");
      send(32'h0055_AA33, "R11");
      idle(4);

      // R1 every request produced exactly one result
      n_total++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R1 pending results actual=%0d expected 0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end
endmodule